// File: doc/BRIEF.md
# Serial Fault-Word Read Sequencer

This block is a serial master built from general logic. It reads a 32-bit fault word out of a chain of shift-register output drivers. It drives two pins, a serial clock and a latch strobe, and it reads one serial data pin. It also watches the driver's active-low fault line.

When the block gets a start request, it runs one read sequence. A sequence has three parts:
- an entry step with the serial clock low;
- a fixed six-step latch/clock preamble;
- 32 clock pulses, while the returned bits are assembled MSB first into a parallel word.

Whenever the fault line changes level, the block runs two full sequences back to back and reports only the second. The driver returns the first read after such a change misaligned by one bit.

A programmable step divider sets every pin transition. With the default of 2500 system clocks per step, a 250 MHz system clock gives a 10 µs half period, so the serial clock runs near 50 kHz. The block reports results with a one-cycle done pulse, a held data word and a valid flag. Start requests that arrive while a read is running are held and served afterwards.

Top module: `fault_scan_master`

## Requirements
- R1: During and right after reset, `sclk_o`, `latch_o`, `busy_o`, `done_o` and `fault_valid_o` are all low.
- R2: Every read sequence begins with step 0, in which the clock is low and the latch keeps its previous level. Steps 1 to 6 then follow in this order: clock high; latch high; clock low; latch low; clock high; latch high.
- R3: The serial clock is low for the whole of step 0 of every sequence. This holds when the sequence follows a previous one directly, including a start request that was held while busy.
- R4: Steps 7 to 70 form 32 pulses: the clock is high on odd steps and low on even steps, and the latch stays high. `sdo_i`, after a two-flop synchronizer, is sampled at the end of each even step from 8 to 70.
- R5: The first sampled bit ends in bit 31 of `fault_data_o` and the last in bit 0. The word is published when the last step ends, together with a one-cycle `done_o` pulse, and `fault_valid_o` is set.
- R6: After a sequence, the latch stays high and the clock stays low until the next sequence begins.
- R7: A start request while idle, with no fault-line change, runs exactly one sequence.
- R8: A change of `nfault_n_i` in either direction, seen while idle, runs two sequences and publishes only the data of the second.
- R9: `fault_valid_o` is cleared as soon as a fault-line change is detected.
- R10: A start request that arrives while busy is held and served by one more sequence after the current one. Each request yields one published word.
- R11: If the fault line changes during any sequence, that sequence runs to its end but is not published. A fresh pair of sequences then follows, and its second result is published.
- R12: Every step lasts exactly `STEP_DIV` system clocks, and the pins change only at step boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request, sampled each cycle |
| nfault_n_i | input | 1 | Driver fault line, active low, asynchronous |
| sdo_i | input | 1 | Serial data returned by the driver, asynchronous |
| sclk_o | output | 1 | Serial clock to the driver |
| latch_o | output | 1 | Latch strobe to the driver |
| busy_o | output | 1 | High while any read sequence runs |
| done_o | output | 1 | One-cycle pulse when a word is published |
| fault_data_o | output | DATA_W | Last published fault word |
| fault_valid_o | output | 1 | Published word is current |

## Verification
The hardest case to reach is a fault-line change that lands in the middle of the first sequence of a pair that an earlier change already started. Only the abort-and-restart path gives correct data there.

The bench models the driver's one-bit slip: a pending misalignment flag, taken at the preamble's final latch rise. It toggles the fault line once, waits about a third of a sequence, then toggles it again. The sequence that takes the slip is therefore one that must be discarded. A design that publishes too early reports a shifted word. The pending-start junction is checked by sampling the clock pin throughout step 0 of the chained sequence.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // entry step plus the six preamble steps
  localparam int PRE_STEPS = 7;

  // serial clock level during step idx of a sequence
  function automatic logic step_clk(input int idx);
    if (idx == 0)      return 1'b0;
    else if (idx <= 2) return 1'b1;
    else if (idx <= 4) return 1'b0;
    else if (idx <= 6) return 1'b1;
    else               return (idx % 2) == 1;
  endfunction

  // latch level during step idx; held is the level carried in from before
  function automatic logic step_latch(input int idx, input logic held);
    if (idx <= 1)      return held;
    else if (idx <= 3) return 1'b1;
    else if (idx <= 5) return 1'b0;
    else               return 1'b1;
  endfunction

  // data is taken at the end of each low half of a shift pulse
  function automatic logic is_sample_step(input int idx);
    return (idx >= PRE_STEPS + 1) && ((idx % 2) == 0);
  endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fsr_step_timer.sv
module fsr_step_timer #(
  parameter int DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (int'(cnt_q) == DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fsr_shifter.sv
module fsr_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] next_o
);
  logic [W-2:0] hist_q;

  // earlier bits move toward the MSB, the new bit enters at bit 0
  assign next_o = {hist_q, bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= next_o[W-2:0];
  end
endmodule

// File: rtl/fault_scan_master.sv
module fault_scan_master
  import fsr_pkg::*;
#(
  parameter int STEP_DIV = 2500,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              nfault_n_i,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              latch_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] fault_data_o,
  output logic              fault_valid_o
);
  localparam int LAST_IDX = PRE_STEPS - 1 + 2 * DATA_W;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);

  // synchronized inputs
  logic [1:0] sync_q;
  logic       nf_s, sdo_s, nf_prev_q;

  fsr_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({nfault_n_i, sdo_i}),
    .q_o   (sync_q)
  );
  assign nf_s  = sync_q[1];
  assign sdo_s = sync_q[0];

  // named internal events
  logic nf_edge, step_tick, seq_end, sample_en, seq_launch, launch_dbl, publish;

  assign nf_edge = nf_s ^ nf_prev_q;

  // sequence state
  logic             busy_q, more_q, edge_pend_q, start_pend_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             sclk_q, latch_q, done_q, valid_q;
  logic [DATA_W-1:0] data_q, word_nxt;

  assign idx_nxt   = idx_q + 1'b1;
  assign seq_end   = busy_q && step_tick && (int'(idx_q) == LAST_IDX);
  assign sample_en = busy_q && step_tick && is_sample_step(int'(idx_q));

  fsr_step_timer #(.DIV(STEP_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .tick  (step_tick)
  );

  fsr_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sample_en),
    .bit_i    (sdo_s),
    .next_o   (word_nxt)
  );

  // decide what starts next and whether a result is published
  always_comb begin
    seq_launch = 1'b0;
    launch_dbl = 1'b0;
    publish    = 1'b0;
    if (!busy_q) begin
      if (nf_edge) begin
        seq_launch = 1'b1;
        launch_dbl = 1'b1;
      end else if (start_i) begin
        seq_launch = 1'b1;
      end
    end else if (seq_end) begin
      if (edge_pend_q || nf_edge) begin
        seq_launch = 1'b1;
        launch_dbl = 1'b1;
      end else if (more_q) begin
        seq_launch = 1'b1;
      end else begin
        publish    = 1'b1;
        seq_launch = start_pend_q || start_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_prev_q    <= 1'b1;
      busy_q       <= 1'b0;
      more_q       <= 1'b0;
      edge_pend_q  <= 1'b0;
      start_pend_q <= 1'b0;
      idx_q        <= '0;
      sclk_q       <= 1'b0;
      latch_q      <= 1'b0;
      done_q       <= 1'b0;
      valid_q      <= 1'b0;
      data_q       <= '0;
    end else begin
      nf_prev_q <= nf_s;
      done_q    <= publish;

      if (publish) begin
        data_q  <= word_nxt;
        valid_q <= 1'b1;
      end else if (nf_edge) begin
        valid_q <= 1'b0;
      end

      if (launch_dbl)              edge_pend_q <= 1'b0;
      else if (busy_q && nf_edge)  edge_pend_q <= 1'b1;

      if (seq_launch)              start_pend_q <= 1'b0;
      else if (busy_q && start_i)  start_pend_q <= 1'b1;

      if (seq_launch) begin
        busy_q <= 1'b1;
        more_q <= launch_dbl;
        idx_q  <= '0;
        sclk_q <= 1'b0;
      end else if (seq_end) begin
        busy_q <= 1'b0;
        sclk_q <= 1'b0;
      end else if (busy_q && step_tick) begin
        idx_q   <= idx_nxt;
        sclk_q  <= step_clk(int'(idx_nxt));
        latch_q <= step_latch(int'(idx_nxt), latch_q);
      end
    end
  end

  assign sclk_o        = sclk_q;
  assign latch_o       = latch_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign fault_data_o  = data_q;
  assign fault_valid_o = valid_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic pin_clk,
  input logic pin_latch,
  input logic done,
  input logic valid,
  input logic step_tick,
  input logic seq_launch,
  input logic nf_edge
);
  assert_idle_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pin_clk);

  assert_idle_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(pin_latch));

  assert_entry_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> (busy && !pin_clk));

  assert_done_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pins_on_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pin_clk) || !$stable(pin_latch)) |-> $past(step_tick || seq_launch));

  assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nf_edge |=> !valid);
endmodule

bind fault_scan_master fsr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_o),
  .pin_clk    (sclk_o),
  .pin_latch  (latch_o),
  .done       (done_o),
  .valid      (fault_valid_o),
  .step_tick  (step_tick),
  .seq_launch (seq_launch),
  .nf_edge    (nf_edge)
);

// File: tb/tb_fault_scan_master.sv
`timescale 1ns/1ps
module tb_fault_scan_master;
  localparam int N    = 4;
  localparam int LAST = 70;

  logic clk = 1'b0;
  logic rst_n, start, nfault_n, sdo;
  logic sclk_o, latch_o, busy_o, done_o, fault_valid_o;
  logic [31:0] fault_data_o;

  always #2 clk = ~clk;  // 250 MHz

  fault_scan_master #(.STEP_DIV(N), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nfault_n_i(nfault_n), .sdo_i(sdo),
    .sclk_o(sclk_o), .latch_o(latch_o), .busy_o(busy_o), .done_o(done_o),
    .fault_data_o(fault_data_o), .fault_valid_o(fault_valid_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver model: shifts a new bit on each clock fall, loads on latch rise,
  // and slips one bit on the first read after a fault-line change
  logic [31:0] slave_val = 32'h0;
  logic [31:0] slave_sh  = 32'h0;
  bit mis_pend = 1'b0;
  bit mis_act  = 1'b0;
  int kbit = 32;
  int seq_cnt = 0;

  initial sdo = 1'b0;

  always @(posedge latch_o) begin
    slave_sh = slave_val;
    kbit     = 0;
    mis_act  = mis_pend;
    mis_pend = 1'b0;
  end

  always @(negedge latch_o) seq_cnt++;

  always @(negedge sclk_o) begin
    if (kbit < 32) begin
      if (mis_act) sdo = (kbit < 31) ? slave_sh[30-kbit] : 1'b0;
      else         sdo = slave_sh[31-kbit];
      kbit++;
    end
  end

  // scoreboard
  logic [31:0] exp_q[$];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && done_o === 1'b1) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 done with nothing expected", fault_data_o, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(fault_data_o === e, "R5/R8 published word", fault_data_o, e);
        chk(fault_valid_o === 1'b1, "R5 valid with done", {31'h0, fault_valid_o}, 32'h1);
      end
    end
  end

  function automatic void exp_pins(input int k, input logic held, output logic c, output logic l);
    case (k)
      0: begin c = 1'b0; l = held; end
      1: begin c = 1'b1; l = held; end
      2: begin c = 1'b1; l = 1'b1; end
      3: begin c = 1'b0; l = 1'b1; end
      4: begin c = 1'b0; l = 1'b0; end
      5: begin c = 1'b1; l = 1'b0; end
      6: begin c = 1'b1; l = 1'b1; end
      default: begin c = ((k - 7) % 2 == 0); l = 1'b1; end
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R12 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    int s0, d0;
    logic ec, el;
    rst_n = 1'b0; start = 1'b0; nfault_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sclk_o === 1'b0, "R1 clk in reset", {31'h0, sclk_o}, 32'h0);
    chk(latch_o === 1'b0, "R1 latch in reset", {31'h0, latch_o}, 32'h0);
    chk(busy_o === 1'b0, "R1 busy in reset", {31'h0, busy_o}, 32'h0);
    chk(done_o === 1'b0, "R1 done in reset", {31'h0, done_o}, 32'h0);
    chk(fault_valid_o === 1'b0, "R1 valid in reset", {31'h0, fault_valid_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && sclk_o === 1'b0 && latch_o === 1'b0, "R1 idle after reset",
        {29'h0, busy_o, sclk_o, latch_o}, 32'h0);

    // R2 R4 R12: full pin pattern of the first read, held latch level is 0
    slave_val = 32'hA5C3_0F81;
    exp_q.push_back(slave_val);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k <= LAST; k++) begin
      exp_pins(k, 1'b0, ec, el);
      chk(sclk_o === ec && latch_o === el, (k < 7) ? "R2 preamble pins" : "R4 shift pins",
          {16'(k), 14'h0, sclk_o, latch_o}, {16'(k), 14'h0, ec, el});
      repeat (N) @(negedge clk);
    end
    // R6: end of sequence, latch left high, clock low
    chk(busy_o === 1'b0 && sclk_o === 1'b0 && latch_o === 1'b1, "R6 pins after read",
        {29'h0, busy_o, sclk_o, latch_o}, 32'h1);
    repeat (20) @(negedge clk);
    chk(latch_o === 1'b1 && sclk_o === 1'b0, "R6 idle hold", {30'h0, sclk_o, latch_o}, 32'h1);

    // R7: single read
    slave_val = 32'h0000_8001;
    exp_q.push_back(slave_val);
    s0 = seq_cnt; d0 = done_cnt;
    pulse_start();
    wait_idle();
    chk(seq_cnt - s0 == 1, "R7 one sequence per start", 32'(seq_cnt - s0), 32'd1);
    chk(done_cnt - d0 == 1, "R7 one result", 32'(done_cnt - d0), 32'd1);

    // R8 R9: fault-line fall, first read slips, second is published
    slave_val = 32'h8000_0004;
    exp_q.push_back(slave_val);
    s0 = seq_cnt; d0 = done_cnt;
    @(negedge clk); nfault_n = 1'b0; mis_pend = 1'b1;
    repeat (4) @(negedge clk);
    chk(fault_valid_o === 1'b0, "R9 valid cleared on edge", {31'h0, fault_valid_o}, 32'h0);
    chk(busy_o === 1'b1, "R8 edge starts read", {31'h0, busy_o}, 32'h1);
    wait_idle();
    chk(seq_cnt - s0 == 2, "R8 two sequences", 32'(seq_cnt - s0), 32'd2);
    chk(done_cnt - d0 == 1, "R8 one result", 32'(done_cnt - d0), 32'd1);

    // R10 R3: start while busy is held and chained
    slave_val = 32'h1234_5678;
    exp_q.push_back(slave_val);
    exp_q.push_back(slave_val);
    s0 = seq_cnt; d0 = done_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    while (done_o !== 1'b1) @(negedge clk);
    chk(sclk_o === 1'b0 && busy_o === 1'b1, "R3 chained entry clk low", {30'h0, busy_o, sclk_o}, 32'h2);
    repeat (N - 1) @(negedge clk);
    chk(sclk_o === 1'b0, "R3 entry clk low full step", {31'h0, sclk_o}, 32'h0);
    @(negedge clk);
    chk(sclk_o === 1'b1, "R12 clk rises after one step", {31'h0, sclk_o}, 32'h1);
    wait_idle();
    chk(seq_cnt - s0 == 2, "R10 sequences", 32'(seq_cnt - s0), 32'd2);
    chk(done_cnt - d0 == 2, "R10 results", 32'(done_cnt - d0), 32'd2);

    // R11: second edge inside the first sequence of a pair
    slave_val = 32'hC001_D00D;
    exp_q.push_back(slave_val);
    s0 = seq_cnt; d0 = done_cnt;
    @(negedge clk); nfault_n = 1'b1; mis_pend = 1'b1;
    repeat (100) @(negedge clk);
    nfault_n = 1'b0; mis_pend = 1'b1;
    wait_idle();
    chk(seq_cnt - s0 == 3, "R11 aborted pair restarted", 32'(seq_cnt - s0), 32'd3);
    chk(done_cnt - d0 == 1, "R11 one result", 32'(done_cnt - d0), 32'd1);
    chk(exp_q.size() == 0, "R5 all results seen", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule